// File: doc/BRIEF.md
# Chip-Select Memory Cycle Controller

This block turns internal bus requests into strobe sequences for slow external parts such as asynchronous SRAM, ROM and EEPROM. A request carries an address, an address-type code, a read/write flag and a byte-lane mask. The block compares it against a small set of bank descriptors that arrive as plain inputs. It picks the first bank that matches and runs a memory cycle with that bank's timing options. During the cycle it drives an active-low chip select for the chosen bank, an output enable for reads, and per-lane write enables for writes. It then acknowledges the requester.

Each bank carries a 4-bit wait count, a relaxed-timing bit that doubles the wait count, and an external-acknowledge mode in which an outside device ends the cycle. It also carries a read-turnaround bit, which adds one idle clock after a read, and two strobe-shaping bits: a late chip-select assertion and an early chip-select and write-strobe release. Until bank 0 is marked valid, it acts as a catch-all boot bank with the slowest timing, so code can be fetched from a boot ROM before any setup.

The requester holds its request steady until it sees the acknowledge. It may present the next request in the acknowledge clock. A request that hits no bank is reported on a separate flag and is never acknowledged.

Top module: `cs_cycle_ctrl`

## Requirements
- R1: Bank i matches when its valid bit is 1, ((addr XOR base) AND addr-mask) is zero, and ((type XOR type-base) AND type-mask) is zero. Among matching banks the lowest index wins. Only bit i of `cs_n` (bit index = bank number) goes low for that cycle.
- R2: A cycle begins at the clock edge that accepts the request. Clocks after that edge are numbered 1, 2, and so on. With internal termination the cycle lasts L = 2 + wait clocks, `ack` is high in clock L only, and no strobe is active after clock L.
- R3: With the relaxed bit set, internal termination gives L = 2 + 2 x wait.
- R4: In external-acknowledge mode the wait count is unused. If `ext_ta` is high at the edge that ends clock n (n >= 1), then clock n+1 is the last clock and carries `ack`.
- R5: In external-acknowledge mode with the relaxed bit set, `ext_ta` at the end of clock 1 is disregarded, so the cycle lasts at least 3 clocks.
- R6: After a read to a bank with the read-turnaround bit set, the next cycle starts one clock later than it otherwise would. The exception is a read to the same bank, which starts without delay.
- R7: `oe_n` is low in every clock of a read cycle and is high otherwise. `we_n[k]` is low on writes while chip select is active and lane k is set in `req_be`. `we_n` stays high on reads.
- R8: With the late-select bit set, chip select is asserted from clock 2 instead of clock 1. The output enable is not affected.
- R9: With the early-release bit set and internal termination, chip select and write strobes are high in clock L. In external-acknowledge mode the bit has no effect.
- R10: While bank 0's valid bit is 0, bank 0 matches every request with 15 wait states and no other option, whatever its other inputs are.
- R11: `nomatch` equals `req_valid` AND no bank matching. Such a request produces no strobe and no `ack`.
- R12: A synchronous active-low reset forces all strobes high and `ack` low, and it aborts a cycle in progress. The clock after `ack` has all strobes inactive. A request waiting in the `ack` clock starts at the earliest at the edge that ends the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present, held until ack |
| req_addr | input | AW | Request address |
| req_atype | input | ATW | Request address-type code |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | LANES | Byte lanes used by the access |
| bank_base | input | NBANK*AW | Per-bank address base, bank i in slice i |
| bank_amask | input | NBANK*AW | Per-bank address compare mask |
| bank_tbase | input | NBANK*ATW | Per-bank address-type base |
| bank_tmask | input | NBANK*ATW | Per-bank address-type compare mask |
| bank_valid | input | NBANK | Bank enabled |
| bank_wait | input | NBANK*4 | Per-bank wait count |
| bank_relax | input | NBANK | Relaxed timing, doubles wait count |
| bank_extack | input | NBANK | Cycle ended by ext_ta |
| bank_rdhold | input | NBANK | Idle clock after reads |
| bank_cslate | input | NBANK | Chip select one clock late |
| bank_csearly | input | NBANK | Chip select and write strobes released one clock early |
| ext_ta | input | 1 | External transfer acknowledge |
| cs_n | output | NBANK | Chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | LANES | Per-lane write enables, active low |
| ack | output | 1 | Transfer acknowledge to requester |
| nomatch | output | 1 | Request hits no bank |

## Verification
The hardest state to reach is the read-turnaround decision. It happens only in the idle clock right after a read's acknowledge, and only when the next request is already waiting. The bench reaches it by issuing the next request in the same clock in which it sees `ack`. It does this for a write to the same bank, a read to the same bank, and a read to another bank. It then measures the clocks until the next acknowledge. The external-acknowledge minimum is reached the same way: `ext_ta` is held high before the request starts, so the very first sampling edge is the one that must be disregarded.

// File: rtl/cs_cycle_pkg.sv
// Shared types for the chip-select cycle controller.
// Assumes wait counts of WS_W bits; CNT_W covers 2 + 2*max wait.
package cs_cycle_pkg;
    localparam int WS_W  = 4;
    localparam int CNT_W = WS_W + 2;

    // Timing options of one bank.
    typedef struct packed {
        logic [WS_W-1:0] wait_cnt;
        logic            relax;
        logic            ext_ack;
        logic            rd_hold;
        logic            cs_late;
        logic            cs_early_off;
    } bank_attr_t;

    // Options used while bank 0 is unconfigured: slowest, internal end.
    localparam bank_attr_t BOOT_ATTR = '{wait_cnt: '1, relax: 1'b0, ext_ack: 1'b0,
                                         rd_hold: 1'b0, cs_late: 1'b0, cs_early_off: 1'b0};

    // Internally terminated cycle length in clocks.
    function automatic logic [CNT_W-1:0] cycle_len(input bank_attr_t a);
        return CNT_W'(2) + (a.relax ? {1'b0, a.wait_cnt, 1'b0} : {2'b00, a.wait_cnt});
    endfunction
endpackage

// File: rtl/cs_bank_match.sv
// Bank decoder: compares a request against every bank's base and mask
// and returns the lowest-numbered matching bank.
// Assumes bank 0 acts as a catch-all while its valid bit is low.
module cs_bank_match #(
    parameter int NBANK = 4,
    parameter int AW    = 16,
    parameter int ATW   = 3,
    parameter int IW    = 2
) (
    input  logic [AW-1:0]        addr,
    input  logic [ATW-1:0]       atype,
    input  logic [NBANK*AW-1:0]  base,
    input  logic [NBANK*AW-1:0]  amask,
    input  logic [NBANK*ATW-1:0] tbase,
    input  logic [NBANK*ATW-1:0] tmask,
    input  logic [NBANK-1:0]     valid,
    output logic                 hit,
    output logic [IW-1:0]        idx,
    output logic                 boot
);
    logic [NBANK-1:0] hits;

    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_cmp
            logic a_eq;
            logic t_eq;
            assign a_eq = (((addr ^ base[gi*AW +: AW]) & amask[gi*AW +: AW]) == '0);
            assign t_eq = (((atype ^ tbase[gi*ATW +: ATW]) & tmask[gi*ATW +: ATW]) == '0);
            if (gi == 0) begin : g_boot
                assign hits[gi] = !valid[gi] || (a_eq && t_eq);
            end else begin : g_norm
                assign hits[gi] = valid[gi] && a_eq && t_eq;
            end
        end
    endgenerate

    // Priority encode: lowest index wins.
    always_comb begin
        idx = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    assign hit  = |hits;
    assign boot = !valid[0];
endmodule

// File: rtl/cs_cycle_seq.sv
// Cycle sequencer: accepts a decoded request, counts the cycle, and
// drives registered chip select, output enable, write enables and ack.
// Assumes the requester holds its request stable until ack.
module cs_cycle_seq
    import cs_cycle_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int LANES = 4,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_wr,
    input  logic [LANES-1:0] req_be,
    input  logic             hit,
    input  logic [IW-1:0]    hit_idx,
    input  bank_attr_t       hit_attr,
    input  logic             ext_ta,
    output logic [NBANK-1:0] cs_n,
    output logic             oe_n,
    output logic [LANES-1:0] we_n,
    output logic             ack
);
    typedef enum logic {ST_IDLE, ST_BUSY} st_t;

    st_t              st_q;
    logic [CNT_W-1:0] cnt_q, len_q;
    bank_attr_t       attr_q;
    logic [IW-1:0]    idx_q, hold_idx_q;
    logic             wr_q, hold_q;
    logic [LANES-1:0] be_q;

    logic             start, drive, fin, cs_on;
    bank_attr_t       cur_attr;
    logic [CNT_W-1:0] cur_len, nxt_cnt, min_ta;
    logic [IW-1:0]    cur_idx;
    logic             cur_wr;
    logic [LANES-1:0] cur_be;

    // Decide what the next clock of the cycle looks like.
    always_comb begin
        start    = (st_q == ST_IDLE) && req_valid && hit &&
                   (!hold_q || (!req_wr && hit_idx == hold_idx_q));
        drive    = start || (st_q == ST_BUSY && !ack);
        cur_attr = start ? hit_attr : attr_q;
        cur_len  = start ? cycle_len(hit_attr) : len_q;
        cur_idx  = start ? hit_idx : idx_q;
        cur_wr   = start ? req_wr : wr_q;
        cur_be   = start ? req_be : be_q;
        nxt_cnt  = start ? CNT_W'(1) : ((cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1));
        min_ta   = attr_q.relax ? CNT_W'(2) : CNT_W'(1);
        fin      = (st_q == ST_BUSY) && !ack &&
                   (attr_q.ext_ack ? (ext_ta && cnt_q >= min_ta) : (nxt_cnt == len_q));
        cs_on    = (nxt_cnt >= (cur_attr.cs_late ? CNT_W'(2) : CNT_W'(1))) &&
                   !(cur_attr.cs_early_off && !cur_attr.ext_ack && nxt_cnt == cur_len);
    end

    // Cycle state, captured request, and read-turnaround bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            len_q      <= '0;
            attr_q     <= '0;
            idx_q      <= '0;
            wr_q       <= 1'b0;
            be_q       <= '0;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            if (st_q == ST_IDLE) hold_q <= 1'b0;
            if (drive) cnt_q <= nxt_cnt;
            if (start) begin
                st_q   <= ST_BUSY;
                len_q  <= cur_len;
                attr_q <= hit_attr;
                idx_q  <= hit_idx;
                wr_q   <= req_wr;
                be_q   <= req_be;
            end else if (st_q == ST_BUSY && ack) begin
                st_q       <= ST_IDLE;
                hold_q     <= !wr_q && attr_q.rd_hold;
                hold_idx_q <= idx_q;
            end
        end
    end

    // Registered strobes and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive) begin
            cs_n <= '1;
            oe_n <= 1'b1;
            we_n <= '1;
            ack  <= 1'b0;
        end else begin
            cs_n <= cs_on ? ~(NBANK'(1) << cur_idx) : '1;
            oe_n <= cur_wr;
            we_n <= (cs_on && cur_wr) ? ~cur_be : '1;
            ack  <= fin;
        end
    end

    AST_CS_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R1
    AST_OE_WE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> (&we_n)); // R7
    AST_EXT_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
                         (ack && attr_q.ext_ack && attr_q.relax) |-> (cnt_q >= CNT_W'(3))); // R5
    AST_ACK_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R12
    AST_END_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                         ack |=> ((&cs_n) && oe_n && (&we_n))); // R12
endmodule

// File: rtl/cs_cycle_ctrl.sv
// Chip-select memory cycle controller top: unpacks per-bank options,
// decodes the request to a bank and runs the strobe sequence.
// Assumes bank inputs change only while no cycle is running.
module cs_cycle_ctrl
    import cs_cycle_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 16,
    parameter int ATW   = 3,
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic [ATW-1:0]        req_atype,
    input  logic                  req_wr,
    input  logic [LANES-1:0]      req_be,
    input  logic [NBANK*AW-1:0]   bank_base,
    input  logic [NBANK*AW-1:0]   bank_amask,
    input  logic [NBANK*ATW-1:0]  bank_tbase,
    input  logic [NBANK*ATW-1:0]  bank_tmask,
    input  logic [NBANK-1:0]      bank_valid,
    input  logic [NBANK*WS_W-1:0] bank_wait,
    input  logic [NBANK-1:0]      bank_relax,
    input  logic [NBANK-1:0]      bank_extack,
    input  logic [NBANK-1:0]      bank_rdhold,
    input  logic [NBANK-1:0]      bank_cslate,
    input  logic [NBANK-1:0]      bank_csearly,
    input  logic                  ext_ta,
    output logic [NBANK-1:0]      cs_n,
    output logic                  oe_n,
    output logic [LANES-1:0]      we_n,
    output logic                  ack,
    output logic                  nomatch
);
    localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1;

    bank_attr_t    bank_attr [NBANK];
    bank_attr_t    sel_attr;
    logic          hit, boot;
    logic [IW-1:0] hit_idx;

    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_attr
            assign bank_attr[gi] = '{wait_cnt: bank_wait[gi*WS_W +: WS_W],
                                     relax: bank_relax[gi], ext_ack: bank_extack[gi],
                                     rd_hold: bank_rdhold[gi], cs_late: bank_cslate[gi],
                                     cs_early_off: bank_csearly[gi]};
        end
    endgenerate

    cs_bank_match #(.NBANK(NBANK), .AW(AW), .ATW(ATW), .IW(IW)) u_match (
        .addr (req_addr),
        .atype(req_atype),
        .base (bank_base),
        .amask(bank_amask),
        .tbase(bank_tbase),
        .tmask(bank_tmask),
        .valid(bank_valid),
        .hit  (hit),
        .idx  (hit_idx),
        .boot (boot)
    );

    // Pick the winning bank's options, boot defaults for an unset bank 0.
    always_comb begin
        sel_attr = (boot && hit_idx == '0) ? BOOT_ATTR : bank_attr[hit_idx];
    end

    assign nomatch = req_valid && !hit;

    cs_cycle_seq #(.NBANK(NBANK), .LANES(LANES), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_wr   (req_wr),
        .req_be   (req_be),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_attr (sel_attr),
        .ext_ta   (ext_ta),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .ack      (ack)
    );

    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                           nomatch |=> ((&cs_n) && oe_n && !ack)); // R11
endmodule

// File: tb/cs_cycle_ctrl_bench.sv
// Bench for cs_cycle_ctrl: a vector table walked by one loop, then
// directed tests for boot, turnaround, external ack and reset.
module cs_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBANK = 4;
    localparam int AW    = 16;
    localparam int ATW   = 3;
    localparam int LANES = 4;
    localparam int NONE  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [ATW-1:0] req_atype = '0;
    logic req_wr = 1'b0;
    logic [LANES-1:0] req_be = '0;
    logic [NBANK*AW-1:0] bank_base = '0, bank_amask = '0;
    logic [NBANK*ATW-1:0] bank_tbase = '0, bank_tmask = '0;
    logic [NBANK-1:0] bank_valid = '0;
    logic [NBANK*4-1:0] bank_wait = '0;
    logic [NBANK-1:0] bank_relax = '0, bank_extack = '0, bank_rdhold = '0;
    logic [NBANK-1:0] bank_cslate = '0, bank_csearly = '0;
    logic ext_ta = 1'b0;
    logic [NBANK-1:0] cs_n;
    logic oe_n;
    logic [LANES-1:0] we_n;
    logic ack, nomatch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int b_late [NBANK] = '{0, 0, 0, 0};
    int b_early[NBANK] = '{0, 0, 0, 0};
    int b_ext  [NBANK] = '{0, 0, 0, 0};

    typedef struct packed {
        logic [15:0] addr;
        logic [2:0]  at;
        logic        wr;
        logic [3:0]  be;
        logic [2:0]  bank;
        logic [5:0]  len;
    } vec_t;

    localparam vec_t VECS[11] = '{
        '{16'h0123, 3'd0, 1'b0, 4'hF, 3'd0, 6'd4},
        '{16'h0FFF, 3'd5, 1'b1, 4'hA, 3'd0, 6'd4},
        '{16'h1234, 3'd1, 1'b0, 4'hF, 3'd1, 6'd8},
        '{16'h1234, 3'd2, 1'b1, 4'h3, 3'd2, 6'd2},
        '{16'h1900, 3'd2, 1'b0, 4'hF, 3'd4, 6'd0},
        '{16'h1900, 3'd1, 1'b1, 4'h1, 3'd1, 6'd8},
        '{16'h1000, 3'd1, 1'b1, 4'hC, 3'd1, 6'd8},
        '{16'h8000, 3'd0, 1'b0, 4'hF, 3'd3, 6'd7},
        '{16'hFFFE, 3'd3, 1'b1, 4'hF, 3'd3, 6'd7},
        '{16'h4000, 3'd0, 1'b0, 4'hF, 3'd4, 6'd0},
        '{16'h0000, 3'd7, 1'b1, 4'h4, 3'd0, 6'd4}
    };

    cs_cycle_ctrl #(.NBANK(NBANK), .AW(AW), .ATW(ATW), .LANES(LANES)) u_cs_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_atype(req_atype), .req_wr(req_wr), .req_be(req_be),
        .bank_base(bank_base), .bank_amask(bank_amask), .bank_tbase(bank_tbase),
        .bank_tmask(bank_tmask), .bank_valid(bank_valid), .bank_wait(bank_wait),
        .bank_relax(bank_relax), .bank_extack(bank_extack), .bank_rdhold(bank_rdhold),
        .bank_cslate(bank_cslate), .bank_csearly(bank_csearly), .ext_ta(ext_ta),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ack(ack), .nomatch(nomatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one request and compare every clock until ack; offset = idle clocks expected first.
    task automatic do_access(input logic [15:0] addr, input logic [2:0] at, input logic wr,
                             input logic [3:0] be, input int ta_clk, input int bank,
                             input int len, input int offset, input string tag);
        int k = 0;
        bit got = 0;
        req_addr = addr; req_atype = at; req_wr = wr; req_be = be; req_valid = 1'b1;
        if (ta_clk == 0) ext_ta = 1'b1;
        while (!got && k < offset + len + 4) begin
            int j;
            bit in_cyc, cs_low;
            logic [3:0] e_cs, e_we;
            @(negedge clk);
            k++;
            j = k - offset;
            in_cyc = (j >= 1) && (j <= len);
            cs_low = in_cyc && (j >= (b_late[bank] != 0 ? 2 : 1)) &&
                     !(b_early[bank] != 0 && b_ext[bank] == 0 && j == len);
            e_cs = cs_low ? ~(4'b0001 << bank) : 4'hF;
            e_we = (cs_low && wr) ? ~be : 4'hF;
            check(cs_n == e_cs, tag, "cs_n", cs_n, e_cs);
            check(oe_n == !(in_cyc && !wr), tag, "oe_n", oe_n, !(in_cyc && !wr));
            check(we_n == e_we, tag, "we_n", we_n, e_we);
            check(ack == (j == len), tag, "ack", ack, (j == len));
            if (ack) got = 1;
            if (k == ta_clk) ext_ta = 1'b1;
        end
        check(got && k == offset + len, tag, "clocks to ack", k, offset + len);
        req_valid = 1'b0;
        ext_ta = 1'b0;
    endtask

    task automatic no_match(input logic [15:0] addr, input logic [2:0] at, input logic wr);
        req_addr = addr; req_atype = at; req_wr = wr; req_be = 4'hF; req_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(nomatch == 1'b1, "R11", "nomatch", nomatch, 1);
            check((cs_n == 4'hF) && oe_n && (we_n == 4'hF) && !ack, "R11", "strobes quiet",
                  {cs_n, oe_n, we_n, ack}, {4'hF, 1'b1, 4'hF, 1'b0});
        end
        req_valid = 1'b0;
        #1;
        check(nomatch == 1'b0, "R11", "nomatch drop", nomatch, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Bank setup; valid bits stay low for the boot phase.
        bank_base  = {16'h8000, 16'h1000, 16'h1000, 16'h0000};
        bank_amask = {16'h8000, 16'hF800, 16'hF000, 16'hF000};
        bank_tbase = {3'd0, 3'd0, 3'd1, 3'd0};
        bank_tmask = {3'd0, 3'd0, 3'd7, 3'd0};
        bank_wait  = {4'd5, 4'd0, 4'd3, 4'd2};
        bank_relax = 4'b0010;
        bank_cslate = 4'b1000;
        bank_csearly = 4'b1000;
        bank_rdhold = 4'b1000;

        // R12: reset state
        idle(3);
        check((cs_n == 4'hF) && oe_n && (we_n == 4'hF) && !ack, "R12", "reset outputs",
              {cs_n, oe_n, we_n, ack}, {4'hF, 1'b1, 4'hF, 1'b0});
        rst_n = 1'b1;
        idle(2);

        // R10: boot bank catches everything with 15 wait states
        do_access(16'h4000, 3'd0, 1'b0, 4'hF, -1, 0, 17, 0, "R10");
        idle(2);
        do_access(16'h9000, 3'd6, 1'b1, 4'h5, -1, 0, 17, 0, "R10");
        idle(2);

        bank_valid = 4'hF;
        b_late[3] = 1;
        b_early[3] = 1;
        idle(2);

        // Table walk: R1 R2 R3 R7 R8 R9 R11
        for (int v = 0; v < 11; v++) begin
            if (VECS[v].bank == 3'd4)
                no_match(VECS[v].addr, VECS[v].at, VECS[v].wr);
            else
                do_access(VECS[v].addr, VECS[v].at, VECS[v].wr, VECS[v].be, -1,
                          int'(VECS[v].bank), int'(VECS[v].len), 0, "R1/R2/R3/R7/R8/R9");
            idle(2);
        end

        // R6: read turnaround on bank 3
        do_access(16'h8000, 3'd0, 1'b0, 4'hF, -1, 3, 7, 0, "R6");
        do_access(16'h8004, 3'd0, 1'b1, 4'h3, -1, 3, 7, 2, "R6 write after read");
        idle(2);
        do_access(16'h8000, 3'd0, 1'b0, 4'hF, -1, 3, 7, 0, "R6");
        do_access(16'h8010, 3'd0, 1'b0, 4'hF, -1, 3, 7, 1, "R6 same-bank read");
        idle(2);
        do_access(16'h8000, 3'd0, 1'b0, 4'hF, -1, 3, 7, 0, "R6");
        do_access(16'h0100, 3'd0, 1'b0, 4'hF, -1, 0, 4, 2, "R6 other-bank read");
        idle(2);
        // R12: no turnaround bank -> back-to-back after one clock
        do_access(16'h0100, 3'd0, 1'b0, 4'hF, -1, 0, 4, 0, "R12");
        do_access(16'h8000, 3'd0, 1'b1, 4'hF, -1, 3, 7, 1, "R12 back-to-back");
        idle(2);
        do_access(16'h8000, 3'd0, 1'b0, 4'hF, -1, 3, 7, 0, "R6");
        idle(2);
        do_access(16'h8008, 3'd0, 1'b1, 4'h8, -1, 3, 7, 0, "R6 turnaround consumed by idle");
        idle(2);

        // R4 R5 R9: bank 2 in external-ack mode, early release must not apply
        bank_extack[2] = 1'b1;
        bank_csearly[2] = 1'b1;
        bank_wait[11:8] = 4'd1;
        b_ext[2] = 1;
        b_early[2] = 1;
        idle(2);
        do_access(16'h1234, 3'd2, 1'b1, 4'h3, 0, 2, 2, 0, "R4/R9");
        idle(2);
        do_access(16'h1234, 3'd2, 1'b0, 4'hF, 5, 2, 6, 0, "R4");
        idle(2);
        bank_relax[2] = 1'b1;
        idle(1);
        do_access(16'h1234, 3'd2, 1'b1, 4'hF, 0, 2, 3, 0, "R5");
        idle(2);
        do_access(16'h1234, 3'd2, 1'b0, 4'hF, 4, 2, 5, 0, "R5");
        idle(2);

        // R12: reset aborts a running cycle
        req_addr = 16'h1000; req_atype = 3'd1; req_wr = 1'b1; req_be = 4'hF; req_valid = 1'b1;
        idle(3);
        check(cs_n == 4'b1101, "R12", "cycle running before reset", cs_n, 4'b1101);
        rst_n = 1'b0;
        idle(1);
        check((cs_n == 4'hF) && oe_n && (we_n == 4'hF) && !ack, "R12", "reset abort",
              {cs_n, oe_n, we_n, ack}, {4'hF, 1'b1, 4'hF, 1'b0});
        req_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        do_access(16'h0200, 3'd0, 1'b1, 4'h2, -1, 0, 4, 0, "R12 recovery");
        idle(2);

        finish_run();
    end
endmodule